// File: doc/BRIEF.md
# Parallel ATA PIO Cycle Generator

This block converts single register read and write requests from a host into timed programmed-I/O bus cycles on a parallel ATA device port. The host presents a request with a four-bit address, write data, a direction flag and a size flag. The block then runs one complete bus cycle. It reports completion with a one-clock done pulse, and for reads it presents the captured word. Address bit 3 selects the control block (device control and alternate status). When that bit is clear, the access goes to the command block (data, error, status and the other taskfile registers). Bits 2:0 travel to the device as the register address.

Timing comes from three programmable values, each counted in clock cycles: total cycle, strobe setup and strobe pulse. The block does not use these values directly:

- It adds one clock to the setup so that ringing on the lines can settle.
- It keeps at least two clocks of recovery.
- It derives the chip-select window from the resulting cycle length.
- It holds the strobe asserted while the device pulls its ready line low.

The timing values reset to PIO mode 0 figures (600 ns cycle, 70 ns setup, 290 ns pulse), rounded up to whole clocks of the configured period. The device data bus is exposed in its pad-facing split form: an output word, an output enable and an input word.

Top module: `pata_pio_engine`

## Requirements
- R1: A request is accepted only on a clock where no cycle is running. `req_done` is high for exactly one clock, the last clock of the cycle. A request held high during a cycle does not start a new one. It is taken on the clock after the done pulse, so the first clock of the next cycle comes two clocks after the done clock.
- R2: Cycle clocks are numbered from 0, starting with the clock after acceptance. The active strobe first goes low at clock `setup+1`. It stays low for `max(pulse,1)` clocks when the device is ready.
- R3: Let active = `setup+1+max(pulse,1)`. The cycle length is L = `max(cycle, active+2)`. `req_done` is high at clock L-1.
- R4: Exactly one chip select is low, from clock 1 through clock L-2. `ata_cs1_n` is used when address bit 3 is 1, and `ata_cs0_n` when it is 0. The other chip select stays high, and both are high outside a cycle.
- R5: Write cycles use the same setup, pulse and length as reads. `ata_wr_n` is the strobe for writes and `ata_rd_n` for reads. The unused strobe stays high for the whole cycle.
- R6: `ata_ready` is looked at only on the last pulse clock. Each clock it is low there holds the strobe low one more clock. Every later event of the cycle (chip-select end, done) shifts by the same number of clocks. Outside that clock, `ata_ready` has no effect.
- R7: A read captures `ata_din` on the clock edge that ends the strobe, which is the value present during the last strobe-low clock. `rd_data` holds that word when `req_done` is high.
- R8: An access is 16 bits wide only when `req_size16` is 1 and the address is 0 (command-block data register). All other accesses use the low byte. Writes drive `{8'h00, wdata[7:0]}`, and reads return `{8'h00, din[7:0]}`.
- R9: `ata_doe` is high only during write cycles. It is high from clock 0 through the last strobe-low clock, and while it is high, `ata_dout` carries the lane-mapped write word.
- R10: After reset, every strobe and chip select is high, `ata_doe`, `req_done` and `rd_data` are zero, and the timing values are `ceil(600/CLK_NS)`, `ceil(70/CLK_NS)` and `ceil(290/CLK_NS)`.
- R11: Timing is written with `cfg_we`, and `cfg_sel` picks the value: 0 for cycle, 1 for setup, 2 for pulse. A write with `cfg_sel` = 3 changes nothing. Timing is sampled when a request is accepted, so a write made during a running cycle applies from the next cycle on.
- R12: While a chip select is low, `ata_addr` equals request address bits 2:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Timing value write strobe |
| cfg_sel | input | 2 | Timing value select: 0 cycle, 1 setup, 2 pulse, 3 none |
| cfg_wdata | input | TW | Timing value in clocks |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 write, 0 read |
| req_size16 | input | 1 | 16-bit access request (honoured for the data register only) |
| req_addr | input | 4 | Bit 3 control block select, bits 2:0 register |
| req_wdata | input | 16 | Write data |
| req_done | output | 1 | One-clock completion pulse |
| rd_data | output | 16 | Captured read word |
| ata_cs0_n | output | 1 | Command-block chip select, active low |
| ata_cs1_n | output | 1 | Control-block chip select, active low |
| ata_addr | output | 3 | Device register address |
| ata_rd_n | output | 1 | Read strobe, active low |
| ata_wr_n | output | 1 | Write strobe, active low |
| ata_dout | output | 16 | Data bus output word |
| ata_doe | output | 1 | Data bus output enable |
| ata_din | input | 16 | Data bus input word |
| ata_ready | input | 1 | Device ready, low stretches the strobe |

## Verification
The bench builds the block with TW = 8 and CLK_NS = 4. The 4 ns period makes the reset timing 150, 18 and 73 clocks, so one full mode-0 cycle fits in a short run. Programmed values are swept over cycle 0 to 12, setup 0 to 3 and pulse 0 to 3, for both reads and writes. This reaches cases where the recovery floor overrides the cycle and cases where it does not, as well as the zero-pulse minimum. Separate runs cover ready stalls of several lengths, a request held high through a cycle, and a timing write made in the middle of a cycle.

// File: rtl/pata_pio_pkg.sv
`timescale 1ns/1ps
package pata_pio_pkg;

    // PIO mode 0 figures used for the reset timing, in nanoseconds
    localparam int unsigned MODE0_CYCLE_NS = 600;
    localparam int unsigned MODE0_SETUP_NS = 70;
    localparam int unsigned MODE0_PULSE_NS = 290;

    typedef enum logic [1:0] {
        CFG_CYCLE = 2'd0,
        CFG_SETUP = 2'd1,
        CFG_PULSE = 2'd2,
        CFG_NONE  = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic        write;
        logic        wide;
        logic        ctrl;
        logic [2:0]  regsel;
        logic [15:0] wdata;
    } pio_req_t;

    function automatic int unsigned ns_to_clk(input int unsigned ns, input int unsigned clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic logic [15:0] lane_map(input logic wide, input logic [15:0] word);
        return wide ? word : {8'h00, word[7:0]};
    endfunction

endpackage

// File: rtl/pio_timing_regs.sv
`timescale 1ns/1ps
module pio_timing_regs
    import pata_pio_pkg::*;
#(
    parameter int TW     = 8,
    parameter int CLK_NS = 10
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [TW-1:0] cfg_wdata,
    output logic [TW-1:0] cyc_o,
    output logic [TW-1:0] setup_o,
    output logic [TW-1:0] pulse_o
);
    localparam int unsigned DEF_CYC   = ns_to_clk(MODE0_CYCLE_NS, CLK_NS);
    localparam int unsigned DEF_SETUP = ns_to_clk(MODE0_SETUP_NS, CLK_NS);
    localparam int unsigned DEF_PULSE = ns_to_clk(MODE0_PULSE_NS, CLK_NS);

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_o   <= TW'(DEF_CYC);
            setup_o <= TW'(DEF_SETUP);
            pulse_o <= TW'(DEF_PULSE);
        end else if (cfg_we) begin
            case (cfg_sel_e'(cfg_sel))
                CFG_CYCLE: cyc_o   <= cfg_wdata;
                CFG_SETUP: setup_o <= cfg_wdata;
                CFG_PULSE: pulse_o <= cfg_wdata;
                default:   ;
            endcase
        end
    end

    // R11: select 3 leaves every timing value untouched
    assert_sel_none_R11: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_sel == 2'd3) |=> ($stable(cyc_o) && $stable(setup_o) && $stable(pulse_o)));
endmodule

// File: rtl/pio_timing_derive.sv
`timescale 1ns/1ps
module pio_timing_derive #(
    parameter int TW = 8,
    parameter int CW = TW + 2
)(
    input  logic [TW-1:0] cyc_i,
    input  logic [TW-1:0] setup_i,
    input  logic [TW-1:0] pulse_i,
    output logic [CW-1:0] strobe_on_o,   // first strobe clock
    output logic [CW-1:0] active_o,      // first clock after the pulse
    output logic [CW-1:0] length_o       // total clocks in the cycle
);
    logic [CW-1:0] pulse_eff;
    logic [CW-1:0] floor_len;

    always_comb begin
        strobe_on_o = CW'(setup_i) + CW'(1);
        pulse_eff   = (pulse_i == '0) ? CW'(1) : CW'(pulse_i);
        active_o    = strobe_on_o + pulse_eff;
        floor_len   = active_o + CW'(2);
        length_o    = (CW'(cyc_i) < floor_len) ? floor_len : CW'(cyc_i);
    end
endmodule

// File: rtl/pio_cycle_seq.sv
`timescale 1ns/1ps
module pio_cycle_seq
    import pata_pio_pkg::*;
#(
    parameter int CW = 10
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  pio_req_t      req_i,
    input  logic [CW-1:0] strobe_on_i,
    input  logic [CW-1:0] active_i,
    input  logic [CW-1:0] length_i,
    input  logic          ready_i,
    output pio_req_t      req_q,
    output logic          strobe_o,
    output logic          cs_on_o,
    output logic          drive_o,
    output logic          capture_o,
    output logic          done_o
);
    logic          busy_q;
    logic [CW-1:0] t_q;
    logic [CW-1:0] son_q, act_q, len_q;
    logic          last_pulse;
    logic          stall;

    always_comb begin
        strobe_o   = busy_q && (t_q >= son_q) && (t_q < act_q);
        last_pulse = strobe_o && (t_q == act_q - CW'(1));
        stall      = last_pulse && !ready_i;
        done_o     = busy_q && (t_q == len_q - CW'(1));
        cs_on_o    = busy_q && (t_q >= CW'(1)) && (t_q < len_q - CW'(1));
        drive_o    = busy_q && req_q.write && (t_q < act_q);
        capture_o  = last_pulse && ready_i && !req_q.write;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            t_q    <= '0;
            son_q  <= '0;
            act_q  <= '0;
            len_q  <= '0;
            req_q  <= '0;
        end else if (!busy_q) begin
            if (req_valid) begin
                busy_q <= 1'b1;
                t_q    <= '0;
                son_q  <= strobe_on_i;
                act_q  <= active_i;
                len_q  <= length_i;
                req_q  <= req_i;
            end
        end else if (done_o) begin
            busy_q <= 1'b0;
        end else if (!stall) begin
            t_q <= t_q + CW'(1);
        end
    end

    // R1: done lasts a single clock
    assert_done_single_R1: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
    // R1: a running cycle is never abandoned before its done clock
    assert_busy_hold_R1: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !done_o) |=> busy_q);
    // R11: timing captured at acceptance stays fixed for the cycle
    assert_timing_frozen_R11: assert property (@(posedge clk) disable iff (rst)
        (busy_q && $past(busy_q)) |-> ($stable(len_q) && $stable(act_q) && $stable(son_q)));
    // R3: at least two recovery clocks precede the end of the cycle
    assert_recovery_floor_R3: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (t_q >= act_q + CW'(1)));
endmodule

// File: rtl/pata_pio_engine.sv
`timescale 1ns/1ps
module pata_pio_engine
    import pata_pio_pkg::*;
#(
    parameter int TW     = 8,
    parameter int CLK_NS = 10
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [TW-1:0] cfg_wdata,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          req_size16,
    input  logic [3:0]    req_addr,
    input  logic [15:0]   req_wdata,
    output logic          req_done,
    output logic [15:0]   rd_data,
    output logic          ata_cs0_n,
    output logic          ata_cs1_n,
    output logic [2:0]    ata_addr,
    output logic          ata_rd_n,
    output logic          ata_wr_n,
    output logic [15:0]   ata_dout,
    output logic          ata_doe,
    input  logic [15:0]   ata_din,
    input  logic          ata_ready
);
    localparam int CW = TW + 2;

    logic [TW-1:0] cyc_r, setup_r, pulse_r;
    logic [CW-1:0] son_d, act_d, len_d;
    pio_req_t      req_in, req_q;
    logic          strobe, cs_on, drive, capture;

    pio_timing_regs #(.TW(TW), .CLK_NS(CLK_NS)) u_regs (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .cyc_o(cyc_r), .setup_o(setup_r), .pulse_o(pulse_r)
    );

    pio_timing_derive #(.TW(TW), .CW(CW)) u_derive (
        .cyc_i(cyc_r), .setup_i(setup_r), .pulse_i(pulse_r),
        .strobe_on_o(son_d), .active_o(act_d), .length_o(len_d)
    );

    always_comb begin
        req_in.write  = req_write;
        req_in.wide   = req_size16 && !req_addr[3] && (req_addr[2:0] == 3'd0);
        req_in.ctrl   = req_addr[3];
        req_in.regsel = req_addr[2:0];
        req_in.wdata  = req_wdata;
    end

    pio_cycle_seq #(.CW(CW)) u_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_i(req_in),
        .strobe_on_i(son_d), .active_i(act_d), .length_i(len_d), .ready_i(ata_ready),
        .req_q(req_q), .strobe_o(strobe), .cs_on_o(cs_on), .drive_o(drive),
        .capture_o(capture), .done_o(req_done)
    );

    assign ata_cs0_n = !(cs_on && !req_q.ctrl);
    assign ata_cs1_n = !(cs_on && req_q.ctrl);
    assign ata_addr  = req_q.regsel;
    assign ata_rd_n  = !(strobe && !req_q.write);
    assign ata_wr_n  = !(strobe && req_q.write);
    assign ata_doe   = drive;
    assign ata_dout  = lane_map(req_q.wide, req_q.wdata);

    always_ff @(posedge clk) begin
        if (rst)          rd_data <= '0;
        else if (capture) rd_data <= lane_map(req_q.wide, ata_din);
    end

    // R4: never both chip selects
    assert_cs_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0({!ata_cs0_n, !ata_cs1_n}));
    // R4: a strobe only inside the chip-select window
    assert_strobe_in_cs_R4: assert property (@(posedge clk) disable iff (rst)
        (!ata_rd_n || !ata_wr_n) |-> (!ata_cs0_n || !ata_cs1_n));
    // R5: read and write strobes never together
    assert_strobe_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
        !(!ata_rd_n && !ata_wr_n));
    // R6: a low ready keeps an asserted strobe asserted
    assert_ready_stretch_R6: assert property (@(posedge clk) disable iff (rst)
        ((!ata_rd_n || !ata_wr_n) && !ata_ready) |=> (!ata_rd_n || !ata_wr_n));
    // R9: the bus is never driven while the read strobe is low
    assert_doe_not_read_R9: assert property (@(posedge clk) disable iff (rst)
        ata_doe |-> ata_rd_n);
endmodule

// File: tb/test_pata_pio_engine.sv
`timescale 1ns/1ps
module test_pata_pio_engine;
    localparam int TW     = 8;
    localparam int CLK_NS = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_sel = 2'd0;
    logic [TW-1:0] cfg_wdata = '0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic          req_size16 = 1'b0;
    logic [3:0]    req_addr = 4'd0;
    logic [15:0]   req_wdata = 16'd0;
    logic          req_done;
    logic [15:0]   rd_data;
    logic          ata_cs0_n, ata_cs1_n, ata_rd_n, ata_wr_n, ata_doe;
    logic [2:0]    ata_addr;
    logic [15:0]   ata_dout;
    logic [15:0]   ata_din = 16'd0;
    logic          ata_ready = 1'b1;

    always #2 clk = ~clk;

    pata_pio_engine #(.TW(TW), .CLK_NS(CLK_NS)) i_pata_pio_engine (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_write(req_write), .req_size16(req_size16),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_done(req_done), .rd_data(rd_data),
        .ata_cs0_n(ata_cs0_n), .ata_cs1_n(ata_cs1_n), .ata_addr(ata_addr),
        .ata_rd_n(ata_rd_n), .ata_wr_n(ata_wr_n), .ata_dout(ata_dout), .ata_doe(ata_doe),
        .ata_din(ata_din), .ata_ready(ata_ready)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int m_cyc, m_set, m_pul;

    task automatic chk(input string tag, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] dev_word(input int t);
        return 16'(t * 263) ^ 16'hA55A;
    endfunction

    task automatic cfg_write(input logic [1:0] sel, input int val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = TW'(val);
        @(negedge clk);
        cfg_we = 1'b0;
        if (sel == 2'd0) m_cyc = val;
        if (sel == 2'd1) m_set = val;
        if (sel == 2'd2) m_pul = val;
    endtask

    task automatic run_cycle(input bit wr, input bit sz16, input bit ctl, input int rg,
                             input logic [15:0] wd, input int stall, input bit hold,
                             input int mid_cyc);
        int s, p, a, l;
        bit wide;
        int st_first = -1, st_cnt = 0, other_st = 0;
        int cs_first = -1, cs_last = -1, cs_cnt = 0, other_cs = 0;
        int doe_first = -1, doe_cnt = 0, dout_bad = 0, addr_bad = 0;
        int done_cnt = 0, done_t = -1, last_low = -1;
        logic [15:0] rdv = 16'd0;
        logic [15:0] wexp;
        string rs;
        s = m_set + 1;
        p = (m_pul == 0) ? 1 : m_pul;
        a = s + p;
        l = (m_cyc < a + 2) ? a + 2 : m_cyc;
        wide = sz16 && !ctl && (rg == 0);
        wexp = wide ? wd : {8'h00, wd[7:0]};
        rs = (stall > 0) ? "R6" : "R2";
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_size16 = sz16;
        req_addr = {ctl, 3'(rg)}; req_wdata = wd; ata_ready = 1'b0;
        for (int t = 0; t < 4000; t++) begin
            @(negedge clk);
            if (!hold) req_valid = 1'b0;
            if ((wr ? ata_wr_n : ata_rd_n) == 1'b0) begin
                if (st_first < 0) st_first = t;
                st_cnt++; last_low = t;
            end
            if ((wr ? ata_rd_n : ata_wr_n) == 1'b0) other_st++;
            if ((ctl ? ata_cs1_n : ata_cs0_n) == 1'b0) begin
                if (cs_first < 0) cs_first = t;
                cs_last = t; cs_cnt++;
                if (ata_addr != 3'(rg)) addr_bad++;
            end
            if ((ctl ? ata_cs0_n : ata_cs1_n) == 1'b0) other_cs++;
            if (ata_doe) begin
                if (doe_first < 0) doe_first = t;
                doe_cnt++;
                if (ata_dout != wexp) dout_bad++;
            end
            if (req_done) begin
                done_cnt++; done_t = t; rdv = rd_data;
                req_valid = 1'b0;
                break;
            end
            if (mid_cyc >= 0 && t == 2) begin
                cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = TW'(mid_cyc);
            end
            if (t == 3) cfg_we = 1'b0;
            ata_din = dev_word(t);
            ata_ready = (st_cnt >= p + stall);
        end
        cfg_we = 1'b0;
        ata_ready = 1'b1;
        if (mid_cyc >= 0) m_cyc = mid_cyc;
        chk({rs, " strobe first clock"}, st_first, s);
        chk({rs, " strobe length"}, st_cnt, p + stall);
        chk("R5 unused strobe stays high", other_st, 0);
        chk("R1 done count", done_cnt, 1);
        chk("R3 done clock", done_t, l - 1 + stall);
        chk("R4 cs first clock", cs_first, 1);
        chk("R4 cs last clock", cs_last, l - 2 + stall);
        chk("R4 cs length", cs_cnt, l - 2 + stall);
        chk("R4 other cs high", other_cs, 0);
        chk("R12 address during cs", addr_bad, 0);
        if (wr) begin
            chk("R9 doe first clock", doe_first, 0);
            chk("R9 doe length", doe_cnt, a + stall);
            chk("R8 write lane", dout_bad, 0);
        end else begin
            logic [15:0] raw;
            raw = dev_word(last_low);
            chk("R9 no doe on read", doe_cnt, 0);
            chk("R7 R8 read word", rdv, wide ? raw : {8'h00, raw[7:0]});
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL R1 watchdog expired: actual 1 expected 0");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        m_cyc = (600 + CLK_NS - 1) / CLK_NS;
        m_set = (70 + CLK_NS - 1) / CLK_NS;
        m_pul = (290 + CLK_NS - 1) / CLK_NS;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: idle state after reset
        chk("R10 cs0 idle", ata_cs0_n, 1);
        chk("R10 cs1 idle", ata_cs1_n, 1);
        chk("R10 rd idle", ata_rd_n, 1);
        chk("R10 wr idle", ata_wr_n, 1);
        chk("R10 doe idle", ata_doe, 0);
        chk("R10 done idle", req_done, 0);
        chk("R10 rd_data zero", rd_data, 0);
        // R10: mode-0 timing straight out of reset, read then write
        run_cycle(1'b0, 1'b1, 1'b0, 0, 16'h1234, 0, 1'b0, -1);
        run_cycle(1'b1, 1'b1, 1'b1, 6, 16'hBEEF, 0, 1'b0, -1);
        // R1: request held high through a cycle, then back to back
        cfg_write(2'd0, 9); cfg_write(2'd1, 1); cfg_write(2'd2, 2);
        run_cycle(1'b0, 1'b0, 1'b0, 7, 16'h0, 0, 1'b1, -1);
        @(negedge clk);
        chk("R1 idle clock after done: done low", req_done, 0);
        chk("R1 idle clock after done: no strobe", ata_rd_n & ata_wr_n, 1);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 4'd2;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R1 first clock of next cycle: cs still high", ata_cs0_n, 1);
        @(negedge clk);
        chk("R1 second clock of next cycle: cs low", ata_cs0_n, 0);
        while (!req_done) @(negedge clk);
        // sweep of programmed timing, R2 R3 R5 R8 R9
        for (int c = 0; c <= 12; c++)
            for (int su = 0; su <= 3; su++)
                for (int pu = 0; pu <= 3; pu++)
                    for (int w = 0; w <= 1; w++) begin
                        int idx;
                        idx = c * 32 + su * 8 + pu * 2 + w;
                        cfg_write(2'd0, c); cfg_write(2'd1, su); cfg_write(2'd2, pu);
                        run_cycle(w[0], idx[2], idx[3] ^ idx[0], (idx / 3) % 8 == 5 ? 0 : (idx / 3) % 8,
                                  16'(idx * 4099) ^ 16'h7E81, 0, 1'b0, -1);
                    end
        // R6: ready stalls of several lengths
        cfg_write(2'd0, 4); cfg_write(2'd1, 2); cfg_write(2'd2, 3);
        for (int st = 1; st <= 5; st++) begin
            run_cycle(1'b0, 1'b1, 1'b0, 0, 16'h0, st, 1'b0, -1);
            run_cycle(1'b1, 1'b0, 1'b1, 6, 16'hC3A5, st, 1'b0, -1);
        end
        // R11: cycle write during a running cycle applies to the next one
        cfg_write(2'd0, 20); cfg_write(2'd1, 0); cfg_write(2'd2, 1);
        run_cycle(1'b0, 1'b0, 1'b0, 3, 16'h0, 0, 1'b0, 30);
        run_cycle(1'b0, 1'b0, 1'b0, 3, 16'h0, 0, 1'b0, -1);
        // R11: select 3 has no effect on the next cycle
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 2'd3; cfg_wdata = 8'd3;
        @(negedge clk);
        cfg_we = 1'b0;
        run_cycle(1'b1, 1'b1, 1'b0, 0, 16'h8001, 0, 1'b0, -1);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule